// File: doc/BRIEF.md
# Audio Serial Port with Sample FIFOs

This block is a master-mode two-channel audio serial port. It generates a bit clock (`sck`) and a channel-select line (`ws`). It shifts transmit samples out on `sdo` and shifts receive samples in from `sdi`. Samples reach the port through an eight-entry transmit FIFO that has a plain write strobe. Received samples leave through an eight-entry receive FIFO that has a plain read strobe. Each FIFO drives two signals: a threshold interrupt, and a level flag that a DMA engine can use as a request.

Software chooses four settings. The sample width is 8, 16, 24 or 32 bits. The port runs in mono or stereo. The framing is either the standard one, where data lags the channel-select edge by one bit, or MSB-justified. Thresholds are compared against the FIFO levels on every cycle. While `en` is low the serial pins are quiet. Each rising edge of `en` starts a new frame from its first bit. Configuration is expected to stay stable while `en` is high.

Top module: `audio_serial_port`

## Requirements
- R1: While `en` is high, `sck` starts low and toggles every CLK_DIV clock cycles, giving a period of 2*CLK_DIV cycles. Within one clock after `en` drops, `sck`, `ws` and `sdo` are all low.
- R2: `cfg_wsize` selects the slot length W: 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 32 bit clocks. A frame is two slots. `ws` is low for the W bits of the left slot and high for the W bits of the right slot, and the first bit after enabling opens a left slot. `ws` and `sdo` change only when `sck` falls, so they are stable at its rising edge.
- R3: With `cfg_msbj`=1, a channel's MSB is sent in the first bit of its `ws` slot. With `cfg_msbj`=0, it is sent one bit clock after the `ws` change, and the very first bit after enabling is 0.
- R4: Each sample is the low W bits of a FIFO word, sent MSB first. Bits above W are ignored.
- R5: In stereo (`cfg_mono`=0), successive transmit FIFO words go to left, right, left, right and so on.
- R6: In mono (`cfg_mono`=1), one FIFO word is taken per frame and sent in both slots.
- R7: `sdi` is sampled on rising `sck`. Each completed slot is written to the receive FIFO as a zero-extended W-bit word, in the order left then right in stereo. In mono only left slots are written.
- R8: The transmit FIFO holds 8 words and `tx_level` reports its fill. A write to a full FIFO is dropped.
- R9: `rx_rdata` shows the oldest receive word, and `rx_rd` removes it. A read of an empty FIFO has no effect.
- R10: One clock after the levels change, `tx_irq` equals (tx_level <= tx_thr) and `rx_irq` equals (rx_level > rx_thr).
- R11: One clock after the levels change, `tx_req` is high when the transmit FIFO is not full and `rx_req` is high when the receive FIFO is not empty.
- R12: A slot that needs a FIFO word while the transmit FIFO is empty sends zeros and sets `tx_underflow`. The flag stays set until `uf_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Runs the serial port; low holds the pins idle |
| cfg_wsize | input | 2 | Sample width select (8/16/24/32) |
| cfg_mono | input | 1 | 1 = mono, 0 = stereo |
| cfg_msbj | input | 1 | 1 = MSB-justified, 0 = one-bit-delayed framing |
| tx_thr | input | LVL_W | Transmit interrupt threshold |
| rx_thr | input | LVL_W | Receive interrupt threshold |
| tx_wr | input | 1 | Transmit FIFO write strobe |
| tx_wdata | input | 32 | Transmit sample word |
| tx_level | output | LVL_W | Transmit FIFO fill |
| rx_rd | input | 1 | Receive FIFO read strobe |
| rx_rdata | output | 32 | Oldest receive word |
| rx_level | output | LVL_W | Receive FIFO fill |
| tx_irq | output | 1 | Transmit level at or below threshold |
| rx_irq | output | 1 | Receive level above threshold |
| tx_req | output | 1 | Transmit FIFO has room |
| rx_req | output | 1 | Receive FIFO holds data |
| tx_underflow | output | 1 | Sticky transmit underflow flag |
| uf_clr | input | 1 | Clears the underflow flag |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Channel select, low = left |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench uses the defaults CLK_DIV=2 and DEPTH=8. A bit clock of four system cycles keeps even a 32-bit stereo frame to 256 cycles, so every sample width and both framings can be run in a few thousand cycles. The eight-entry depth lets nine writes reach the full and dropped-write case, and lets the receive FIFO hold all the words of several frames. `sdi` is looped back from `sdo`, so the words received can be compared with the words sent, and the captured `ws`/`sdo` stream is decoded bit by bit.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int SAMPLE_W = 32;

  typedef enum logic [1:0] {
    WSZ_8  = 2'd0,
    WSZ_16 = 2'd1,
    WSZ_24 = 2'd2,
    WSZ_32 = 2'd3
  } wsize_e;

  // slot length in bit clocks: 8 * (sel + 1)
  function automatic logic [6:0] slot_len(input wsize_e sel);
    return {2'b00, sel, 3'b000} + 7'd8;
  endfunction
endpackage

// File: rtl/asp_fifo.sv
module asp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [LVL_W-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  assign do_wr   = wr_en && (level != LVL_W'(DEPTH));
  assign do_rd   = rd_en && (level != '0);
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/asp_bclk.sv
module asp_bclk #(
  parameter int CLK_DIV = 2,
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck,
  output logic fall_tick,
  output logic rise_tick
);
  logic [CW-1:0] cnt;
  logic          armed, wrap;

  always_comb begin
    wrap      = armed && (cnt == CW'(CLK_DIV - 1));
    fall_tick = run && (!armed || (wrap && sck));
    rise_tick = run && wrap && !sck;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      armed <= 1'b0;
      sck   <= 1'b0;
    end else begin
      armed <= 1'b1;
      cnt   <= (!armed || wrap) ? '0 : cnt + CW'(1);
      if (wrap) sck <= !sck;
    end
  end
endmodule

// File: rtl/asp_rx_deser.sv
module asp_rx_deser #(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          rise_tick,
  input  logic          sdi,
  input  logic [6:0]    pos,
  input  logic [6:0]    slot,
  input  logic          mono,
  output logic          push,
  output logic [SW-1:0] word
);
  logic [SW-1:0] sh, nxt, mask;
  logic          armed, slot_end;

  always_comb begin
    nxt      = {sh[SW-2:0], sdi};
    mask     = ~({SW{1'b1}} << slot);
    slot_end = (pos == slot - 7'd1) || (pos == {slot[5:0], 1'b0} - 7'd1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sh    <= '0;
      armed <= 1'b0;
      push  <= 1'b0;
      word  <= '0;
    end else begin
      push <= 1'b0;
      if (rise_tick) begin
        sh <= nxt;
        if (pos == 7'd0 || pos == slot) armed <= 1'b1;
        if (slot_end) begin
          push <= armed && !(mono && pos >= slot);
          word <= nxt & mask;
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int DEPTH   = 8,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       cfg_wsize,
  input  logic             cfg_mono,
  input  logic             cfg_msbj,
  input  logic [LVL_W-1:0] tx_thr,
  input  logic [LVL_W-1:0] rx_thr,
  input  logic             tx_wr,
  input  logic [31:0]      tx_wdata,
  output logic [LVL_W-1:0] tx_level,
  input  logic             rx_rd,
  output logic [31:0]      rx_rdata,
  output logic [LVL_W-1:0] rx_level,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             tx_req,
  output logic             rx_req,
  output logic             tx_underflow,
  input  logic             uf_clr,
  output logic             sck,
  output logic             ws,
  output logic             sdo,
  input  logic             sdi
);
  localparam int SW = SAMPLE_W;

  logic          fall_t, rise_t;
  logic [6:0]    slot, frame, bcnt, bnext, pnext, pos_q;
  logic          started, slot_start, right_n, need_pop, tx_empty, tx_pop;
  logic [SW-1:0] tx_head, word_n, aligned, cur, left_hold;
  logic          rx_push;
  logic [SW-1:0] rx_word;

  asp_bclk #(.CLK_DIV(CLK_DIV)) u_bclk (
    .clk(clk), .rst(rst), .run(en),
    .sck(sck), .fall_tick(fall_t), .rise_tick(rise_t)
  );

  asp_fifo #(.W(SW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .wr_en(tx_wr), .wr_data(tx_wdata),
    .rd_en(tx_pop), .rd_data(tx_head), .level(tx_level)
  );

  asp_fifo #(.W(SW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .wr_en(rx_push), .wr_data(rx_word),
    .rd_en(rx_rd), .rd_data(rx_rdata), .level(rx_level)
  );

  asp_rx_deser #(.SW(SW)) u_rx (
    .clk(clk), .rst(rst), .en(en), .rise_tick(rise_t), .sdi(sdi),
    .pos(pos_q), .slot(slot), .mono(cfg_mono),
    .push(rx_push), .word(rx_word)
  );

  // bit counter runs over the frame; pnext is the data position, which
  // trails the frame position by one bit in the delayed framing
  always_comb begin
    slot  = slot_len(wsize_e'(cfg_wsize));
    frame = {slot[5:0], 1'b0};
    bnext = 7'd0;
    if (started && (bcnt + 7'd1 != frame)) bnext = bcnt + 7'd1;
    if (cfg_msbj)          pnext = bnext;
    else if (bnext == '0)  pnext = frame - 7'd1;
    else                   pnext = bnext - 7'd1;
    slot_start = (pnext == 7'd0) || (pnext == slot);
    right_n    = (pnext >= slot);
    need_pop   = slot_start && !(right_n && cfg_mono);
    tx_empty   = (tx_level == '0);
    if (right_n && cfg_mono) word_n = left_hold;
    else                     word_n = tx_empty ? '0 : tx_head;
    aligned    = word_n << (7'd32 - slot);
    tx_pop     = fall_t && need_pop && !tx_empty;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      bcnt      <= '0;
      pos_q     <= '0;
      started   <= 1'b0;
      cur       <= '0;
      left_hold <= '0;
      ws        <= 1'b0;
      sdo       <= 1'b0;
    end else if (fall_t) begin
      started <= 1'b1;
      bcnt    <= bnext;
      pos_q   <= pnext;
      ws      <= (bnext >= slot);
      if (slot_start) begin
        sdo <= aligned[SW-1];
        cur <= aligned << 1;
        if (!right_n) left_hold <= word_n;
      end else begin
        sdo <= cur[SW-1];
        cur <= cur << 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                   tx_underflow <= 1'b0;
    else if (fall_t && need_pop && tx_empty)   tx_underflow <= 1'b1;
    else if (uf_clr)                           tx_underflow <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_irq <= 1'b1;
      rx_irq <= 1'b0;
      tx_req <= 1'b1;
      rx_req <= 1'b0;
    end else begin
      tx_irq <= (tx_level <= tx_thr);
      rx_irq <= (rx_level > rx_thr);
      tx_req <= (tx_level != LVL_W'(DEPTH));
      rx_req <= (rx_level != '0);
    end
  end
endmodule

// File: rtl/asp_sva.sv
module asp_sva #(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             sck,
  input logic             ws,
  input logic             sdo,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_thr,
  input logic [LVL_W-1:0] rx_thr,
  input logic             tx_irq,
  input logic             rx_irq,
  input logic             tx_req,
  input logic             rx_req,
  input logic             tx_underflow,
  input logic             uf_clr
);
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sck && !ws && !sdo)); // R1
  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (ws != $past(ws)) |-> !sck); // R2
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (sdo != $past(sdo)) |-> !sck); // R2
  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH))); // R8
  AST_TX_IRQ: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tx_irq == ($past(tx_level) <= $past(tx_thr)))); // R10
  AST_RX_IRQ: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rx_irq == ($past(rx_level) > $past(rx_thr)))); // R10
  AST_TX_REQ: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tx_req == ($past(tx_level) != LVL_W'(DEPTH)))); // R11
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tx_underflow && !uf_clr) |=> tx_underflow); // R12
endmodule

bind audio_serial_port asp_sva #(.DEPTH(DEPTH)) u_sva (
  .clk(clk), .rst(rst), .en(en), .sck(sck), .ws(ws), .sdo(sdo),
  .tx_level(tx_level), .rx_level(rx_level), .tx_thr(tx_thr), .rx_thr(rx_thr),
  .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_req(tx_req), .rx_req(rx_req),
  .tx_underflow(tx_underflow), .uf_clr(uf_clr)
);

// File: tb/sim_audio_serial_port.sv
module sim_audio_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 2;
  localparam int DEPTH      = 8;
  localparam int MAXB       = 256;

  logic        clk = 1'b0;
  logic        rst, en, cfg_mono, cfg_msbj, tx_wr, rx_rd, uf_clr;
  logic [1:0]  cfg_wsize;
  logic [3:0]  tx_thr, rx_thr, tx_level, rx_level;
  logic [31:0] tx_wdata, rx_rdata;
  logic        tx_irq, rx_irq, tx_req, rx_req, tx_underflow, sck, ws, sdo, sdi;

  int  checks = 0, failures = 0;
  bit  done = 1'b0, cap_on = 1'b0;
  int  ncap = 0;
  time t0, t1;
  logic cws [MAXB];
  logic csd [MAXB];

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign sdi = sdo; // loopback

  audio_serial_port #(.CLK_DIV(CLK_DIV), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .en(en), .cfg_wsize(cfg_wsize), .cfg_mono(cfg_mono),
    .cfg_msbj(cfg_msbj), .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .tx_level(tx_level), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .rx_level(rx_level), .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_req(tx_req),
    .rx_req(rx_req), .tx_underflow(tx_underflow), .uf_clr(uf_clr),
    .sck(sck), .ws(ws), .sdo(sdo), .sdi(sdi)
  );

  always @(posedge sck) begin
    if (cap_on) begin
      if (ncap < MAXB) begin
        cws[ncap] = ws;
        csd[ncap] = sdo;
      end
      if (ncap == 0) t0 = $time;
      if (ncap == 1) t1 = $time;
      ncap++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] src_word(input int k, input int nwr);
    if (k < nwr && k < DEPTH) return 32'h9E3779B9 * 32'(k + 1);
    return 32'h0;
  endfunction

  task automatic t_reset();
    chk(!sck && !ws && !sdo, "R1 idle pins after reset", {sck, ws, sdo}, 0);
    chk(tx_level == 0 && rx_level == 0, "R8 empty after reset", tx_level + rx_level, 0);
    chk(tx_irq && !rx_irq, "R10 irq after reset", {tx_irq, rx_irq}, 2);
    chk(tx_req && !rx_req, "R11 req after reset", {tx_req, rx_req}, 2);
    chk(!tx_underflow, "R12 underflow clear after reset", tx_underflow, 0);
  endtask

  task automatic run_case(input int wsel, input bit mono, input bit msbj, input int nfr,
                          input int nwr, input int txt, input int rxt, input string tag);
    int W, nstore, used, nrx, target, errs, idx, d;
    logic [31:0] w, msk;
    W      = 8 * (wsel + 1);
    nstore = (nwr > DEPTH) ? DEPTH : nwr;
    used   = nfr * (mono ? 1 : 2);
    nrx    = used;
    d      = msbj ? 0 : 1;
    msk    = (W == 32) ? 32'hFFFFFFFF : ((32'h1 << W) - 32'h1);
    @(negedge clk);
    cfg_wsize = 2'(wsel); cfg_mono = mono; cfg_msbj = msbj;
    tx_thr = 4'(txt); rx_thr = 4'(rxt);
    for (int k = 0; k < nwr; k++) begin
      tx_wdata = 32'h9E3779B9 * 32'(k + 1);
      tx_wr = 1'b1;
      @(negedge clk);
    end
    tx_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_level == 4'(nstore), {tag, " R8 tx level after writes"}, tx_level, nstore);
    chk(tx_req == (nstore != DEPTH), {tag, " R11 tx_req"}, tx_req, nstore != DEPTH);
    chk(tx_irq == (nstore <= txt), {tag, " R10 tx_irq"}, tx_irq, nstore <= txt);
    ncap = 0; cap_on = 1'b1; en = 1'b1;
    target = 2 * W * nfr + d;
    while (ncap < target) @(negedge clk);
    en = 1'b0; cap_on = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sck && !ws && !sdo, {tag, " R1 pins idle after disable"}, {sck, ws, sdo}, 0);
    chk((t1 - t0) == time'(2 * CLK_DIV * CLK_PERIOD), {tag, " R1 sck period"}, t1 - t0,
        2 * CLK_DIV * CLK_PERIOD);
    errs = 0;
    for (int i = 0; i < ncap; i++)
      if (cws[i] !== ((i % (2 * W)) >= W)) errs++;
    chk(errs == 0, {tag, " R2 ws slot pattern mismatches"}, errs, 0);
    errs = 0;
    if (!msbj && csd[0] !== 1'b0) errs++;
    for (int f = 0; f < nfr; f++)
      for (int c = 0; c < 2; c++) begin
        w = mono ? src_word(f, nwr) : src_word(2 * f + c, nwr);
        for (int i = 0; i < W; i++) begin
          idx = f * 2 * W + c * W + i + d;
          if (csd[idx] !== w[W - 1 - i]) errs++;
        end
      end
    chk(errs == 0, {tag, " R3 R4 data bit mismatches"}, errs, 0);
    chk(tx_level == 4'((nstore > used) ? nstore - used : 0), {tag, " R5 R6 words consumed"},
        tx_level, (nstore > used) ? nstore - used : 0);
    chk(tx_underflow == (used > nstore), {tag, " R12 underflow flag"}, tx_underflow, used > nstore);
    if (used > nstore) begin
      uf_clr = 1'b1;
      @(negedge clk);
      uf_clr = 1'b0;
      @(negedge clk);
      chk(!tx_underflow, {tag, " R12 underflow cleared"}, tx_underflow, 0);
    end
    chk(rx_level == 4'(nrx), {tag, " R7 rx word count"}, rx_level, nrx);
    chk(rx_req == (nrx != 0), {tag, " R11 rx_req"}, rx_req, nrx != 0);
    chk(rx_irq == (nrx > rxt), {tag, " R10 rx_irq"}, rx_irq, nrx > rxt);
    errs = 0;
    for (int j = 0; j < nrx; j++) begin
      if (rx_rdata !== (src_word(j, nwr) & msk)) errs++;
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
    end
    chk(errs == 0, {tag, " R7 received word mismatches"}, errs, 0);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    @(negedge clk);
    chk(rx_level == 0, {tag, " R9 read of empty rx fifo"}, rx_level, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b0; cfg_wsize = 2'd0; cfg_mono = 1'b0; cfg_msbj = 1'b1;
    tx_thr = 4'd0; rx_thr = 4'd0; tx_wr = 1'b0; tx_wdata = '0; rx_rd = 1'b0; uf_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_case(1, 1'b0, 1'b1, 2, 4, 4, 2, "msbj stereo 16b R5");
    run_case(2, 1'b0, 1'b0, 2, 4, 3, 4, "delayed stereo 24b R5");
    run_case(0, 1'b1, 1'b0, 3, 3, 2, 1, "delayed mono 8b R6");
    run_case(3, 1'b0, 1'b1, 1, 2, 1, 0, "msbj stereo 32b R4");
    run_case(0, 1'b0, 1'b1, 4, 9, 7, 7, "overflow 8b R8");
    run_case(0, 1'b0, 1'b1, 1, 1, 0, 1, "underflow 8b R12");
    run_case(1, 1'b1, 1'b1, 2, 2, 2, 3, "msbj mono 16b R6");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule